// File: doc/BRIEF.md
# Split Transaction Retry Manager

This block sits between two producers of outgoing asynchronous request packets, a control source and a data source, and a link transmitter. Both producers push packet descriptors into one shared queue. Packets leave in the order they were queued, and neither source has priority over the other. The block keeps exactly one packet in flight. It offers the head of the queue to the link, waits for the link's acknowledge code, and then decides what happens to that packet.

A complete acknowledge ends the transaction. Any busy acknowledge sends the same packet again, up to a programmable number of retransmissions. A pending acknowledge starts a split-transaction window in which a response carrying the packet's transaction label must arrive. When retries run out, when the window expires, or when the acknowledge code is one the block does not accept, the transaction is dropped and a failure code is latched. A level interrupt is raised and stays up until software clears it. Each finished transaction, whether it succeeded or failed, advances the transaction label by one.

Top module: `split_retry_mgr`

## Requirements
- R1: Requests from both sources enter one queue and are offered to the link strictly in arrival order. When both sources request in the same cycle, the control request is queued ahead of the data request.
- R2: `ctlReady` and `dataReady` are high exactly when the queue holds at most DEPTH-2 entries. A request made while its ready is low is ignored and never transmitted.
- R3: `txValid` stays high with `txSrc`, `txDesc` and `txLabel` unchanged until `txReady` is seen. After the handshake, `txValid` stays low until the transaction ends, so only one packet is ever outstanding.
- R4: An acknowledge code of 4'h1 (complete) ends the transaction. `doneValid` pulses in the following cycle, and if the queue is not empty the next packet's `txValid` is high in that same cycle.
- R5: An acknowledge code of 4'h4, 4'h5 or 4'h6 (busy) with retries left makes the block offer the same packet again in the next cycle, with the same descriptor and label and with `txRetry` high.
- R6: A busy acknowledge after `cfgMaxRetry` retransmissions drops the packet and sets `errCode` to 1. With `cfgMaxRetry` = 0, the first busy acknowledge already fails.
- R7: An acknowledge code of 4'h2 (pending) opens a window of `cfgSplitLimit` cycles. A response whose `rspLabel` equals the packet's label within that window ends the transaction with a `doneValid` pulse.
- R8: If no matching response arrives within `cfgSplitLimit` cycles after the pending acknowledge, the packet is dropped and `errCode` becomes 2. `irq` is still low one cycle before that point.
- R9: Acknowledges arriving while no packet awaits one, and responses arriving outside a split window or carrying another label, have no effect.
- R10: Any other acknowledge code drops the packet and sets `errCode` to 3.
- R11: `errCode` and `irq` are registered in the cycle after a failure and hold until `errClear`. A newer failure overwrites the code, and a failure wins over a clear in the same cycle.
- R12: `txLabel` is 0 after reset and increases by one, modulo 2^LABEL_W, each time a transaction ends by success or by failure.
- R13: After reset, `txValid`, `doneValid`, `irq` and `errCode` are 0 and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlReq | input | 1 | Control source pushes a descriptor |
| ctlDesc | input | DESC_W | Control packet descriptor |
| ctlReady | output | 1 | Queue can take a control request |
| dataReq | input | 1 | Data source pushes a descriptor |
| dataDesc | input | DESC_W | Data packet descriptor |
| dataReady | output | 1 | Queue can take a data request |
| txValid | output | 1 | Packet offered to the link |
| txReady | input | 1 | Link takes the offered packet |
| txSrc | output | 1 | Source of offered packet: 0 control, 1 data |
| txDesc | output | DESC_W | Offered packet descriptor |
| txLabel | output | LABEL_W | Transaction label of the offered packet |
| txRetry | output | 1 | Offered packet is a retransmission |
| ackValid | input | 1 | Acknowledge code is present |
| ackCode | input | 4 | Acknowledge code from the link |
| rspValid | input | 1 | A response packet was received |
| rspLabel | input | LABEL_W | Transaction label of the received response |
| doneValid | output | 1 | One-cycle pulse: transaction completed successfully |
| cfgMaxRetry | input | RETRY_W | Maximum retransmissions after busy |
| cfgSplitLimit | input | TIMER_W | Split response window in cycles (0 acts as 1) |
| errCode | output | 2 | Latest failure: 1 busy exhausted, 2 split timeout, 3 rejected |
| irq | output | 1 | Failure interrupt level |
| errClear | input | 1 | Clears errCode and irq |

## Verification
The hardest states to reach are the edges of the two limits. One is a busy acknowledge that arrives exactly when the retry budget is used up. The other is a response, or its absence, in the last cycle of the split window. A further case is a full queue that receives requests from both sources in the same cycle. The bench drives a model of the link. For each transaction it picks an outcome at random, and it chains busy acknowledges until the budget is exhausted under several values of `cfgMaxRetry`, including zero. It counts idle cycles after a pending acknowledge, so that a response lands anywhere up to the last legal cycle, or the timeout is observed one cycle early and then at the edge where it should occur. Directed sequences cover error overwrite without a clear, stray acknowledges and responses, and wrong-label responses.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    ST_SEND = 2'd0,
    ST_WACK = 2'd1,
    ST_WRSP = 2'd2
  } srmState_e;

  localparam logic [3:0] ACK_COMPLETE = 4'h1;
  localparam logic [3:0] ACK_PENDING  = 4'h2;
  localparam logic [3:0] ACK_BUSY_X   = 4'h4;
  localparam logic [3:0] ACK_BUSY_A   = 4'h5;
  localparam logic [3:0] ACK_BUSY_B   = 4'h6;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_BUSY   = 2'd1;
  localparam logic [1:0] ERR_SPLIT  = 2'd2;
  localparam logic [1:0] ERR_REJECT = 2'd3;

  localparam logic SRC_CTL  = 1'b0;
  localparam logic SRC_DATA = 1'b1;

  typedef struct packed {
    logic       pop;
    logic       done;
    logic       retryInc;
    logic       retryClr;
    logic       timerInc;
    logic       timerClr;
    logic       errSet;
    logic [1:0] errVal;
  } srmStrobe_t;

endpackage

// File: rtl/srm_datapath.sv
module srm_datapath
  import srm_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DESC_W  = 8,
  parameter int LABEL_W = 6,
  parameter int RETRY_W = 3,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlReq,
  input  logic [DESC_W-1:0]  ctlDesc,
  input  logic               dataReq,
  input  logic [DESC_W-1:0]  dataDesc,
  input  srmStrobe_t         strobe,
  input  logic [RETRY_W-1:0] cfgMaxRetry,
  input  logic [TIMER_W-1:0] cfgSplitLimit,
  input  logic [LABEL_W-1:0] rspLabel,
  input  logic               errClear,
  output logic               ctlReady,
  output logic               dataReady,
  output logic               headValid,
  output logic               headSrc,
  output logic [DESC_W-1:0]  headDesc,
  output logic [LABEL_W-1:0] curLabel,
  output logic               retrying,
  output logic               retryExhausted,
  output logic               timerExpired,
  output logic               rspMatch,
  output logic [1:0]         errCode,
  output logic               irq,
  output logic               doneValid
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM_FOR_TWO = CNT_W'(DEPTH - 2);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << PTR_W));

  // Slot storage
  logic                 slotSrc  [DEPTH];
  logic [DESC_W-1:0]    slotDesc [DEPTH];
  logic [PTR_W-1:0]     rdPtr, wrPtr, wrPtrNext, dataSlot, wrStep1, wrStep2;
  logic [CNT_W-1:0]     fill;
  logic                 ctlPush, dataPush;

  // Pointer wrap: natural overflow when the depth is a power of two
  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    if (POW2) return p + 1'b1;
    else      return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign ctlReady  = (fill <= ROOM_FOR_TWO);
  assign dataReady = (fill <= ROOM_FOR_TWO);
  assign ctlPush   = ctlReq && ctlReady;
  assign dataPush  = dataReq && dataReady;
  assign wrStep1   = stepPtr(wrPtr);
  assign wrStep2   = stepPtr(wrStep1);
  // Control wins the earlier slot when both push together
  assign dataSlot  = ctlPush ? wrStep1 : wrPtr;

  always_comb begin
    unique case ({ctlPush, dataPush})
      2'b11:         wrPtrNext = wrStep2;
      2'b10, 2'b01:  wrPtrNext = wrStep1;
      default:       wrPtrNext = wrPtr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctlPush) begin
      slotSrc[wrPtr]  <= SRC_CTL;
      slotDesc[wrPtr] <= ctlDesc;
    end
    if (dataPush) begin
      slotSrc[dataSlot]  <= SRC_DATA;
      slotDesc[dataSlot] <= dataDesc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      wrPtr <= wrPtrNext;
      if (strobe.pop) rdPtr <= stepPtr(rdPtr);
      fill <= fill + CNT_W'(ctlPush) + CNT_W'(dataPush) - CNT_W'(strobe.pop);
    end
  end

  assign headValid = (fill != '0);
  assign headSrc   = slotSrc[rdPtr];
  assign headDesc  = slotDesc[rdPtr];

  // Retry attempt counter
  logic [RETRY_W-1:0] retryCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                retryCnt <= '0;
    else if (strobe.retryClr) retryCnt <= '0;
    else if (strobe.retryInc) retryCnt <= retryCnt + 1'b1;
  end
  assign retrying       = (retryCnt != '0);
  assign retryExhausted = (retryCnt >= cfgMaxRetry);

  // Split-transaction window counter
  logic [TIMER_W-1:0] splitTimer;
  always_ff @(posedge clk) begin
    if (!rstN)                splitTimer <= '0;
    else if (strobe.timerClr) splitTimer <= '0;
    else if (strobe.timerInc) splitTimer <= splitTimer + 1'b1;
  end
  assign timerExpired = ({1'b0, splitTimer} + 1'b1) >= {1'b0, cfgSplitLimit};

  // Transaction label, one step per finished transaction
  always_ff @(posedge clk) begin
    if (!rstN)           curLabel <= '0;
    else if (strobe.pop) curLabel <= curLabel + 1'b1;
  end
  assign rspMatch = (rspLabel == curLabel);

  // Failure record and interrupt level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCode   <= ERR_NONE;
      irq       <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= strobe.done;
      if (strobe.errSet) begin
        errCode <= strobe.errVal;
        irq     <= 1'b1;
      end else if (errClear) begin
        errCode <= ERR_NONE;
        irq     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/srm_control.sv
module srm_control
  import srm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       headValid,
  input  logic       txReady,
  input  logic       ackValid,
  input  logic [3:0] ackCode,
  input  logic       rspValid,
  input  logic       rspMatch,
  input  logic       retryExhausted,
  input  logic       timerExpired,
  output logic       txValid,
  output srmStrobe_t strobe
);

  srmState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SEND;
    else       state <= stateNext;
  end

  // Ends the current transaction and drops the head of the queue
  function automatic srmStrobe_t finish(input logic ok, input logic [1:0] code);
    srmStrobe_t s;
    s          = '0;
    s.pop      = 1'b1;
    s.retryClr = 1'b1;
    s.done     = ok;
    s.errSet   = !ok;
    s.errVal   = code;
    return s;
  endfunction

  always_comb begin
    stateNext = state;
    strobe    = '0;
    txValid   = 1'b0;
    unique case (state)
      ST_SEND: begin
        txValid = headValid;
        if (headValid && txReady) stateNext = ST_WACK;
      end
      ST_WACK: begin
        if (ackValid) begin
          stateNext = ST_SEND;
          unique case (ackCode)
            ACK_COMPLETE: strobe = finish(1'b1, ERR_NONE);
            ACK_PENDING: begin
              strobe.timerClr = 1'b1;
              stateNext       = ST_WRSP;
            end
            ACK_BUSY_X, ACK_BUSY_A, ACK_BUSY_B: begin
              if (retryExhausted) strobe = finish(1'b0, ERR_BUSY);
              else                strobe.retryInc = 1'b1;
            end
            default: strobe = finish(1'b0, ERR_REJECT);
          endcase
        end
      end
      ST_WRSP: begin
        if (rspValid && rspMatch) begin
          strobe    = finish(1'b1, ERR_NONE);
          stateNext = ST_SEND;
        end else if (timerExpired) begin
          strobe    = finish(1'b0, ERR_SPLIT);
          stateNext = ST_SEND;
        end else begin
          strobe.timerInc = 1'b1;
        end
      end
      default: stateNext = ST_SEND;
    endcase
  end

endmodule

// File: rtl/split_retry_mgr.sv
module split_retry_mgr
  import srm_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DESC_W  = 8,
  parameter int LABEL_W = 6,
  parameter int RETRY_W = 3,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlReq,
  input  logic [DESC_W-1:0]  ctlDesc,
  output logic               ctlReady,
  input  logic               dataReq,
  input  logic [DESC_W-1:0]  dataDesc,
  output logic               dataReady,
  output logic               txValid,
  input  logic               txReady,
  output logic               txSrc,
  output logic [DESC_W-1:0]  txDesc,
  output logic [LABEL_W-1:0] txLabel,
  output logic               txRetry,
  input  logic               ackValid,
  input  logic [3:0]         ackCode,
  input  logic               rspValid,
  input  logic [LABEL_W-1:0] rspLabel,
  output logic               doneValid,
  input  logic [RETRY_W-1:0] cfgMaxRetry,
  input  logic [TIMER_W-1:0] cfgSplitLimit,
  output logic [1:0]         errCode,
  output logic               irq,
  input  logic               errClear
);

  srmStrobe_t strobe;
  logic headValid, retryExhausted, timerExpired, rspMatch;

  srm_control u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .headValid      (headValid),
    .txReady        (txReady),
    .ackValid       (ackValid),
    .ackCode        (ackCode),
    .rspValid       (rspValid),
    .rspMatch       (rspMatch),
    .retryExhausted (retryExhausted),
    .timerExpired   (timerExpired),
    .txValid        (txValid),
    .strobe         (strobe)
  );

  srm_datapath #(
    .DEPTH   (DEPTH),
    .DESC_W  (DESC_W),
    .LABEL_W (LABEL_W),
    .RETRY_W (RETRY_W),
    .TIMER_W (TIMER_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctlReq         (ctlReq),
    .ctlDesc        (ctlDesc),
    .dataReq        (dataReq),
    .dataDesc       (dataDesc),
    .strobe         (strobe),
    .cfgMaxRetry    (cfgMaxRetry),
    .cfgSplitLimit  (cfgSplitLimit),
    .rspLabel       (rspLabel),
    .errClear       (errClear),
    .ctlReady       (ctlReady),
    .dataReady      (dataReady),
    .headValid      (headValid),
    .headSrc        (txSrc),
    .headDesc       (txDesc),
    .curLabel       (txLabel),
    .retrying       (txRetry),
    .retryExhausted (retryExhausted),
    .timerExpired   (timerExpired),
    .rspMatch       (rspMatch),
    .errCode        (errCode),
    .irq            (irq),
    .doneValid      (doneValid)
  );

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int DESC_W  = 8,
  parameter int LABEL_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               txValid,
  input logic               txReady,
  input logic               txSrc,
  input logic [DESC_W-1:0]  txDesc,
  input logic [LABEL_W-1:0] txLabel,
  input logic               txRetry,
  input logic               doneValid,
  input logic [1:0]         errCode,
  input logic               irq,
  input logic               errClear
);

  // R3: offered packet is held steady until the link takes it
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txDesc) && $stable(txSrc) && $stable(txLabel));

  // R3: nothing new is offered right after a handshake
  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txValid);

  // R5: a retransmission flag only appears together with an offer
  assert_retry_offer_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRetry) |-> txValid);

  // R11: interrupt level persists until cleared
  assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq && !errClear |=> irq);

  // R11: a raised interrupt always carries a failure code
  assert_irq_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> errCode != 2'd0);

  // R12: a successful completion comes with a label advance
  assert_done_label_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> txLabel == LABEL_W'($past(txLabel) + 1'b1));

endmodule

bind split_retry_mgr srm_checker #(.DESC_W(DESC_W), .LABEL_W(LABEL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txValid   (txValid),
  .txReady   (txReady),
  .txSrc     (txSrc),
  .txDesc    (txDesc),
  .txLabel   (txLabel),
  .txRetry   (txRetry),
  .doneValid (doneValid),
  .errCode   (errCode),
  .irq       (irq),
  .errClear  (errClear)
);

// File: tb/sim_split_retry_mgr.sv
module sim_split_retry_mgr;

  localparam int DEPTH   = 4;
  localparam int DESC_W  = 8;
  localparam int LABEL_W = 6;
  localparam int RETRY_W = 3;
  localparam int TIMER_W = 8;
  localparam int SPLIT   = 5;

  logic clk = 1'b0;
  logic rstN;
  logic ctlReq, dataReq, txReady, ackValid, rspValid, errClear;
  logic [DESC_W-1:0] ctlDesc, dataDesc;
  logic [3:0] ackCode;
  logic [LABEL_W-1:0] rspLabel;
  logic [RETRY_W-1:0] cfgMaxRetry;
  logic [TIMER_W-1:0] cfgSplitLimit;
  logic ctlReady, dataReady, txValid, txSrc, txRetry, doneValid, irq;
  logic [DESC_W-1:0] txDesc;
  logic [LABEL_W-1:0] txLabel;
  logic [1:0] errCode;

  always #4 clk = ~clk;

  split_retry_mgr #(
    .DEPTH(DEPTH), .DESC_W(DESC_W), .LABEL_W(LABEL_W),
    .RETRY_W(RETRY_W), .TIMER_W(TIMER_W)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .ctlReq(ctlReq), .ctlDesc(ctlDesc), .ctlReady(ctlReady),
    .dataReq(dataReq), .dataDesc(dataDesc), .dataReady(dataReady),
    .txValid(txValid), .txReady(txReady), .txSrc(txSrc), .txDesc(txDesc),
    .txLabel(txLabel), .txRetry(txRetry),
    .ackValid(ackValid), .ackCode(ackCode),
    .rspValid(rspValid), .rspLabel(rspLabel),
    .doneValid(doneValid), .cfgMaxRetry(cfgMaxRetry), .cfgSplitLimit(cfgSplitLimit),
    .errCode(errCode), .irq(irq), .errClear(errClear)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  logic [DESC_W:0] mq[$];   // {src, desc}
  int expLabel = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nextLabel(input int l);
    return (l + 1) % (1 << LABEL_W);
  endfunction

  function automatic bit expReady(input int fill);
    return fill <= DEPTH - 2;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pushPhase(input int n);
    for (int i = 0; i < n; i++) begin
      bit rdy;
      bit c, d;
      logic [DESC_W-1:0] cd, dd;
      rdy = expReady(mq.size());
      chk("R2 ctlReady", ctlReady, rdy);
      chk("R2 dataReady", dataReady, rdy);
      c = 1'($urandom % 2); d = 1'($urandom % 2);
      cd = DESC_W'($urandom); dd = DESC_W'($urandom);
      ctlReq = c; ctlDesc = cd; dataReq = d; dataDesc = dd;
      if (rdy) begin
        if (c) mq.push_back({1'b0, cd});   // R1: control first
        if (d) mq.push_back({1'b1, dd});
      end
      @(negedge clk);
    end
    ctlReq = 0; dataReq = 0;
  endtask

  task automatic pushBoth(input logic [DESC_W-1:0] cd, input logic [DESC_W-1:0] dd);
    ctlReq = 1; ctlDesc = cd; dataReq = 1; dataDesc = dd;
    mq.push_back({1'b0, cd});
    mq.push_back({1'b1, dd});
    @(negedge clk);
    ctlReq = 0; dataReq = 0;
  endtask

  task automatic clearErr();
    errClear = 1;
    @(negedge clk);
    errClear = 0;
    chk("R11 irq cleared", irq, 0);
    chk("R11 errCode cleared", errCode, 0);
  endtask

  // outcome: -1 random, 0 complete, 1 busy, 2 pending+rsp, 3 pending timeout, 4 reject
  task automatic serviceOne(input int forced, input bit keepErr);
    logic [DESC_W:0] e;
    int retries;
    bit over;
    e = mq[0];
    retries = 0;
    over = 0;
    while (!over) begin
      int r;
      int oc;
      chk("R1 txValid", txValid, 1);
      chk("R1 txSrc", txSrc, e[DESC_W]);
      chk("R1 txDesc", txDesc, e[DESC_W-1:0]);
      chk("R12 txLabel", txLabel, expLabel);
      chk("R5 txRetry", txRetry, retries != 0);
      if ($urandom % 3 == 0) begin
        ackValid = 1; ackCode = 4'h1; rspValid = 1; rspLabel = LABEL_W'(expLabel);
        @(negedge clk);
        ackValid = 0; rspValid = 0;
        chk("R9 stray ignored txValid", txValid, 1);
        chk("R9 stray ignored desc", txDesc, e[DESC_W-1:0]);
        chk("R9 stray no done", doneValid, 0);
      end
      txReady = 1;
      @(negedge clk);
      txReady = 0;
      chk("R3 no offer while outstanding", txValid, 0);
      repeat ($urandom % 3) @(negedge clk);
      if (forced >= 0) oc = forced;
      else begin
        r = int'($urandom % 10);
        oc = (r < 3) ? 0 : (r < 6) ? 1 : (r < 8) ? 2 : (r < 9) ? 3 : 4;
      end
      ackValid = 1;
      case (oc)
        0: begin
          ackCode = 4'h1;
          @(negedge clk); ackValid = 0;
          chk("R4 doneValid", doneValid, 1);
          chk("R4 no irq", irq, 0);
          over = 1;
        end
        1: begin
          ackCode = 4'(4 + $urandom % 3);
          @(negedge clk); ackValid = 0;
          if (retries == int'(cfgMaxRetry)) begin
            chk("R6 irq", irq, 1);
            chk("R6 errCode busy", errCode, 1);
            chk("R6 no done", doneValid, 0);
            over = 1;
          end else begin
            retries++;
          end
        end
        2: begin
          int k;
          ackCode = 4'h2;
          @(negedge clk); ackValid = 0;
          k = int'($urandom % SPLIT);
          for (int i = 0; i < k; i++) begin
            rspValid = 1'($urandom % 2); rspLabel = LABEL_W'(nextLabel(expLabel));
            @(negedge clk);
          end
          rspValid = 1; rspLabel = LABEL_W'(expLabel);
          @(negedge clk); rspValid = 0;
          chk("R7 doneValid", doneValid, 1);
          chk("R7 no irq", irq, 0);
          over = 1;
        end
        3: begin
          ackCode = 4'h2;
          @(negedge clk); ackValid = 0;
          for (int i = 0; i < SPLIT - 1; i++) begin
            rspValid = 1'($urandom % 2); rspLabel = LABEL_W'(nextLabel(expLabel));
            @(negedge clk);
          end
          rspValid = 0;
          chk("R8 irq not early", irq, 0);
          @(negedge clk);
          chk("R8 irq", irq, 1);
          chk("R8 errCode split", errCode, 2);
          chk("R8 no done", doneValid, 0);
          over = 1;
        end
        default: begin
          ackCode = 4'hD;
          @(negedge clk); ackValid = 0;
          chk("R10 irq", irq, 1);
          chk("R10 errCode reject", errCode, 3);
          over = 1;
        end
      endcase
    end
    void'(mq.pop_front());
    expLabel = nextLabel(expLabel);
    chk("R12 label advance", txLabel, expLabel);
    chk("R4 next offer", txValid, mq.size() > 0);
    if (irq && !keepErr) clearErr();
  endtask

  initial begin
    void'($urandom(32'd7781));
    rstN = 0; ctlReq = 0; dataReq = 0; txReady = 0; ackValid = 0; rspValid = 0;
    errClear = 0; ctlDesc = '0; dataDesc = '0; ackCode = '0; rspLabel = '0;
    cfgMaxRetry = 3'd2; cfgSplitLimit = TIMER_W'(SPLIT);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R13 txValid", txValid, 0);
    chk("R13 doneValid", doneValid, 0);
    chk("R13 irq", irq, 0);
    chk("R13 errCode", errCode, 0);
    chk("R13 ctlReady", ctlReady, 1);
    chk("R13 dataReady", dataReady, 1);
    chk("R12 label reset", txLabel, 0);

    // R9: response and acknowledge with nothing in flight
    ackValid = 1; ackCode = 4'h1; rspValid = 1; rspLabel = '0;
    @(negedge clk);
    ackValid = 0; rspValid = 0;
    chk("R9 idle no done", doneValid, 0);
    chk("R9 idle label", txLabel, 0);

    // R1: same-cycle requests, control ahead
    pushBoth(8'h11, 8'h22);
    serviceOne(0, 0);
    serviceOne(0, 0);

    // R11: failure overwrites an uncleared one
    ctlReq = 1; ctlDesc = 8'hA5; mq.push_back({1'b0, 8'hA5});
    @(negedge clk); ctlReq = 0;
    serviceOne(4, 1);
    cfgMaxRetry = '0;
    dataReq = 1; dataDesc = 8'h3C; mq.push_back({1'b1, 8'h3C});
    @(negedge clk); dataReq = 0;
    serviceOne(1, 0);

    // Random rounds
    for (int round = 0; round < 45; round++) begin
      cfgMaxRetry = RETRY_W'($urandom % 4);
      pushPhase(1 + int'($urandom % 6));
      while (mq.size() > 0) serviceOne(-1, 0);
    end

    // R2: fill up, then requests while not ready are dropped
    cfgMaxRetry = 3'd1;
    pushBoth(8'h01, 8'h02);
    pushBoth(8'h03, 8'h04);
    chk("R2 full ctlReady", ctlReady, 0);
    ctlReq = 1; ctlDesc = 8'hEE; dataReq = 1; dataDesc = 8'hEF;
    @(negedge clk);
    ctlReq = 0; dataReq = 0;
    while (mq.size() > 0) serviceOne(0, 0);
    chk("R2 dropped requests absent", txValid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule